// File: doc/BRIEF.md
# Timer interrupt router

This block sits between the fire pulses of a set of timer channels and the interrupt outputs of a timer unit. Each channel is routed to one of the output lines through its own route field, or, when the unit runs in legacy replacement mode, channel 0 and channel 1 take over lines 0 and 8. Each channel signals either as a level, which sets a status bit and holds the line until software clears it by writing ones, or as an edge, which gives a one-cycle pulse and leaves the status bit clear.

A channel can instead be switched to message signalling. In that mode a firing raises no line. It issues one 32-bit write whose address and data come from that channel's 64-bit message route word. Writes are offered on a valid/ready port that holds one request at a time. Outside legacy mode, two external legacy interrupt inputs, a periodic tick source and a clock-chip source, are passed to lines 0 and 8. An enable output for an external interval timer is dropped while legacy mode is on.

Top module: `irq_router`

## Requirements
- R1: After reset the status bits are 0, the message request is not valid, the interval-timer enable is 1, and every line is low while the external inputs are low.
- R2: A firing of an enabled level-type channel (level bit 1, message bit 0) sets its status bit on that clock edge. Its routed line is high from then on until the bit is cleared.
- R3: A firing of an enabled edge-type channel (level bit 0) raises its routed line for exactly one cycle and clears its status bit.
- R4: Outside legacy mode, channel i drives the line numbered by its 5-bit route field, bits [5i+4:5i] of the packed route input. Channels that share a line are ORed.
- R5: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold. Other channels keep their route fields.
- R6: A status write clears exactly the status bits written as 1. Bits written as 0 are kept. A level firing in the same cycle as a clear of its own bit leaves the bit set.
- R7: A firing is ignored while the channel enable or the global enable is low. While either is low, the channel's status bit is 0 from the next edge on.
- R8: In message mode, a firing of an enabled channel sets neither the status bit nor a line. It produces exactly one request whose address is bits [64i+63:64i+32] and whose data is bits [64i+31:64i] of the message route input. The request stays valid and stable until accepted. When several requests are pending, the lowest channel number goes first.
- R9: Turning on message mode for a channel clears its status bit on the next edge and removes its line drive.
- R10: Outside legacy mode, line 0 follows the tick input and line 8 follows the clock input, each one cycle late. In legacy mode neither input reaches a line.
- R11: The interval-timer enable is the inverse of the legacy mode input, one cycle late. On leaving legacy mode, line 8 shows the clock input level recorded while legacy mode was on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy replacement mode |
| tmr_en | input | NUM_TMR | Per-channel enable |
| tmr_level | input | NUM_TMR | 1 = level type, 0 = edge type |
| tmr_msg | input | NUM_TMR | 1 = message signalling |
| fire | input | NUM_TMR | Channel fire pulses |
| tmr_route | input | NUM_TMR*5 | Packed line numbers, 5 bits per channel |
| msg_route | input | NUM_TMR*64 | Packed message words, address in the upper half |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | NUM_TMR | Status write data, 1 clears |
| ext_tick | input | 1 | External periodic tick interrupt |
| ext_clk | input | 1 | External clock-chip interrupt |
| msg_ready | input | 1 | Message sink accepts |
| irq_out | output | NUM_LINES | Interrupt lines |
| sts | output | NUM_TMR | Status bits |
| ivt_en | output | 1 | Interval-timer enable |
| msg_valid | output | 1 | Message request valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench clears a status bit in the same cycle its channel fires again. A design that let the clear win would lose that interrupt. Two channels share one line and only one of them is cleared, which catches a router that drops the line when any sharer clears. Two message requests are queued while the sink stalls, which exposes a request that changes while waiting, the wrong service order, or a duplicated write. Legacy mode is entered and left with the clock input changing in between, so a design that did not keep tracking that input would restore a stale level on line 8.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_TMR   = 4,
  parameter int NUM_LINES = 32,
  parameter int LEG_A     = 0,
  parameter int LEG_B     = 8,
  localparam int RW       = $clog2(NUM_LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic                    legacy_en,
  input  logic [NUM_TMR-1:0]      tmr_en,
  input  logic [NUM_TMR-1:0]      tmr_level,
  input  logic [NUM_TMR-1:0]      tmr_msg,
  input  logic [NUM_TMR-1:0]      fire,
  input  logic [NUM_TMR*RW-1:0]   tmr_route,
  input  logic [NUM_TMR*64-1:0]   msg_route,
  input  logic                    sts_wr,
  input  logic [NUM_TMR-1:0]      sts_wdata,
  input  logic                    ext_tick,
  input  logic                    ext_clk,
  input  logic                    msg_ready,
  output logic [NUM_LINES-1:0]    irq_out,
  output logic [NUM_TMR-1:0]      sts,
  output logic                    ivt_en,
  output logic                    msg_valid,
  output logic [31:0]             msg_addr,
  output logic [31:0]             msg_data
);

  logic [NUM_TMR-1:0] pulse, pend, msg_q, grant;
  logic               legacy_q, tick_q, clk_q;
  logic [31:0]        sel_a, sel_d;

  wire [NUM_TMR-1:0] live     = tmr_en & {NUM_TMR{glb_en}};
  wire [NUM_TMR-1:0] hit      = fire & live;
  wire [NUM_TMR-1:0] msg_rise = tmr_msg & ~msg_q;
  wire [NUM_TMR-1:0] clr      = sts_wr ? (sts_wdata & sts) : '0;
  wire [NUM_TMR-1:0] edge_hit = hit & ~tmr_level & ~tmr_msg;
  wire [NUM_TMR-1:0] lvl_hit  = hit & tmr_level & ~tmr_msg;
  wire [NUM_TMR-1:0] sts_nxt  = ((sts & ~clr & ~edge_hit) | lvl_hit) & live & ~msg_rise;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    sel_a = '0;
    sel_d = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (pend[i] && !found) begin
        found    = 1'b1;
        grant[i] = !msg_valid;
        sel_a    = msg_route[i*64+32 +: 32];
        sel_d    = msg_route[i*64 +: 32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts       <= '0;
      pulse     <= '0;
      pend      <= '0;
      msg_q     <= '0;
      legacy_q  <= 1'b0;
      tick_q    <= 1'b0;
      clk_q     <= 1'b0;
      ivt_en    <= 1'b1;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      sts      <= sts_nxt;
      pulse    <= edge_hit;
      pend     <= (pend & ~grant) | (hit & tmr_msg);
      msg_q    <= tmr_msg;
      legacy_q <= legacy_en;
      ivt_en   <= !legacy_en;
      tick_q   <= ext_tick;
      clk_q    <= ext_clk;
      if (msg_valid && msg_ready) begin
        msg_valid <= 1'b0;
      end else if (!msg_valid && |pend) begin
        msg_valid <= 1'b1;
        msg_addr  <= sel_a;
        msg_data  <= sel_d;
      end
    end
  end

  always_comb begin
    logic [RW-1:0] idx;
    irq_out = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (legacy_q && i == 0)      idx = RW'(LEG_A);
      else if (legacy_q && i == 1) idx = RW'(LEG_B);
      else                         idx = tmr_route[i*RW +: RW];
      irq_out[idx] = irq_out[idx] | ((sts[i] | pulse[i]) & ~tmr_msg[i]);
    end
    if (!legacy_q) begin
      irq_out[LEG_A] = irq_out[LEG_A] | tick_q;
      irq_out[LEG_B] = irq_out[LEG_B] | clk_q;
    end
  end

  generate
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
      p_off_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !live[g] |=> !sts[g]);
      p_edge_no_sts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse[g] |-> !sts[g]);
      p_msg_on_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_msg[g]) |=> !sts[g]);
      p_wr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && sts_wdata[g] && !fire[g]) |=> !sts[g]);
    end
  endgenerate

  p_msg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  p_ivt_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_en |=> !ivt_en);
  p_ivt_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_en |=> ivt_en);

endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int NT = 4;
  localparam int NL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 0, legacy_en = 0, sts_wr = 0, ext_tick = 0, ext_clk = 0, msg_ready = 0;
  logic [NT-1:0] tmr_en = '0, tmr_level = '0, tmr_msg = '0, fire = '0, sts_wdata = '0;
  logic [NT*5-1:0] tmr_route = '0;
  logic [NT*64-1:0] msg_route = '0;
  logic [NL-1:0] irq_out;
  logic [NT-1:0] sts;
  logic ivt_en, msg_valid;
  logic [31:0] msg_addr, msg_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_router #(.NUM_TMR(NT), .NUM_LINES(NL)) i_irq_router (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_en(legacy_en),
    .tmr_en(tmr_en), .tmr_level(tmr_level), .tmr_msg(tmr_msg), .fire(fire),
    .tmr_route(tmr_route), .msg_route(msg_route), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .ext_tick(ext_tick), .ext_clk(ext_clk), .msg_ready(msg_ready),
    .irq_out(irq_out), .sts(sts), .ivt_en(ivt_en), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_fire(input logic [NT-1:0] f);
    fire = f; cyc(); fire = '0;
  endtask

  task automatic wr_sts(input logic [NT-1:0] d);
    sts_wr = 1; sts_wdata = d; cyc(); sts_wr = 0; sts_wdata = '0;
  endtask

  task automatic t_reset;
    chk("R1 sts", sts, 0);
    chk("R1 irq", irq_out, 0);
    chk("R1 ivt_en", ivt_en, 1);
    chk("R1 msg_valid", msg_valid, 0);
  endtask

  task automatic t_level;
    tmr_route[2*5 +: 5] = 5'd13; tmr_level[2] = 1;
    pulse_fire(4'b0100);
    chk("R2 sts set", sts, 4'b0100);
    chk("R2 R4 line13", irq_out, 32'h1 << 13);
    cyc(3);
    chk("R2 line held", irq_out, 32'h1 << 13);
    wr_sts(4'b1011);
    chk("R6 zero bits keep", sts, 4'b0100);
    wr_sts(4'b0100);
    chk("R6 cleared", sts, 0);
    chk("R6 line low", irq_out, 0);
  endtask

  task automatic t_edge;
    tmr_route[3*5 +: 5] = 5'd20; tmr_level[3] = 0;
    pulse_fire(4'b1000);
    chk("R3 pulse high", irq_out, 32'h1 << 20);
    chk("R3 sts clear", sts, 0);
    cyc();
    chk("R3 pulse one cycle", irq_out, 0);
  endtask

  task automatic t_share;
    tmr_route[0 +: 5] = 5'd5; tmr_route[2*5 +: 5] = 5'd5;
    tmr_level[0] = 1; tmr_level[2] = 1;
    pulse_fire(4'b0101);
    chk("R4 shared line", irq_out, 32'h1 << 5);
    wr_sts(4'b0001);
    chk("R6 selective clear", sts, 4'b0100);
    chk("R4 line kept by sharer", irq_out, 32'h1 << 5);
    wr_sts(4'b0100);
    chk("R4 shared line low", irq_out, 0);
  endtask

  task automatic t_race;
    tmr_level[2] = 1;
    pulse_fire(4'b0100);
    fire = 4'b0100; sts_wr = 1; sts_wdata = 4'b0100;
    cyc();
    fire = '0; sts_wr = 0; sts_wdata = '0;
    chk("R6 fire beats clear", sts, 4'b0100);
    wr_sts(4'b0100);
  endtask

  task automatic t_disabled;
    tmr_en[1] = 0; tmr_level[1] = 1; tmr_route[1*5 +: 5] = 5'd9;
    pulse_fire(4'b0010);
    chk("R7 channel off sts", sts, 0);
    chk("R7 channel off irq", irq_out, 0);
    tmr_en[1] = 1; glb_en = 0;
    pulse_fire(4'b0001);
    chk("R7 global off sts", sts, 0);
    glb_en = 1;
    pulse_fire(4'b0001);
    chk("R7 precheck set", sts, 4'b0001);
    tmr_en[0] = 0; cyc();
    chk("R7 disable clears sts", sts, 0);
    chk("R7 disable lowers line", irq_out, 0);
    tmr_en[0] = 1;
  endtask

  task automatic t_legacy;
    ext_clk = 1; ext_tick = 1; cyc();
    chk("R10 passthrough", irq_out, (32'h1 << 8) | 32'h1);
    ext_clk = 0; legacy_en = 1; cyc();
    chk("R11 ivt low", ivt_en, 0);
    chk("R10 legacy blocks ext", irq_out, 0);
    tmr_route[0 +: 5] = 5'd3; tmr_route[1*5 +: 5] = 5'd4; tmr_route[2*5 +: 5] = 5'd6;
    tmr_level[2:0] = 3'b111;
    pulse_fire(4'b0111);
    chk("R5 legacy mapping", irq_out, (32'h1 << 8) | (32'h1 << 6) | 32'h1);
    wr_sts(4'b0111);
    ext_clk = 1; ext_tick = 0; cyc(2);
    chk("R10 clk blocked in legacy", irq_out, 0);
    legacy_en = 0; cyc();
    chk("R11 ivt high", ivt_en, 1);
    chk("R11 line8 restored", irq_out, 32'h1 << 8);
    ext_clk = 0; cyc();
  endtask

  task automatic t_msg;
    tmr_route[1*5 +: 5] = 5'd7; tmr_level[1] = 1;
    pulse_fire(4'b0010);
    chk("R9 pre sts", sts, 4'b0010);
    tmr_msg[1] = 1; cyc();
    chk("R9 msg on clears sts", sts, 0);
    chk("R9 msg on line low", irq_out, 0);
    msg_route[1*64 +: 64] = {32'hA000_0010, 32'h0000_00D1};
    msg_route[3*64 +: 64] = {32'hA000_0020, 32'h0000_00D3};
    tmr_msg[3] = 1; msg_ready = 0;
    pulse_fire(4'b1010);
    chk("R8 no sts", sts, 0);
    chk("R8 no line", irq_out, 0);
    cyc();
    chk("R8 valid", msg_valid, 1);
    chk("R8 lowest first addr", msg_addr, 32'hA000_0010);
    chk("R8 data", msg_data, 32'hD1);
    cyc(2);
    chk("R8 held", {msg_valid, msg_addr, msg_data}, {1'b1, 32'hA000_0010, 32'hD1});
    msg_ready = 1; cyc();
    chk("R8 accepted", msg_valid, 0);
    cyc();
    chk("R8 second addr", {msg_valid, msg_addr, msg_data}, {1'b1, 32'hA000_0020, 32'hD3});
    cyc();
    chk("R8 no duplicate a", msg_valid, 0);
    cyc();
    chk("R8 no duplicate b", msg_valid, 0);
    msg_ready = 0; tmr_msg = '0; cyc();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc();
    t_reset();
    glb_en = 1; tmr_en = '1;
    t_level();
    t_edge();
    t_share();
    t_race();
    t_disabled();
    t_legacy();
    t_msg();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule